// File: doc/BRIEF.md
# SD Host Command Path: Issue, Serialize and Response Capture

This block owns the command half of an SD host controller. Software writes a command word together with an argument. If no command is already in flight, the block decodes the word, builds a 48-bit command frame and shifts it out on the single command line. It then waits for the card's reply and reports how the exchange ended. The command word carries the command index, the response format, two check enables, a flag for commands that use the data lines, and the transfer direction.

The card clock is taken to be the core clock, so the line carries one bit per cycle. Short replies are 48 bits and long replies are 136 bits. The reply is checked against its CRC7, its index field and its stop bit, subject to the enables in the command word. The payload goes into a 128-bit response vector. A single-cycle event then marks success or names each fault found.

Two status flags let software tell whether a new command may be issued. One covers the command line. The other covers the data lines, and the data engine releases it.

Top module: `sdc_cmd_issue`

## Requirements
- R1: After reset, `cmd_inhibit` and `dat_inhibit` are 0, every event output is 0, `cmd_oe` is 0, `cmd_out` is 1 and `resp_words` is zero.
- R2: A `cmd_wr` pulse while `cmd_inhibit` is 0 is accepted, and `cmd_inhibit` reads 1 from the next cycle. Starting on that cycle, `cmd_oe` is high for exactly 48 cycles while `cmd_out` carries, MSB first: a 0, a 1, `cmd_word[29:24]`, the 32-bit argument, CRC7 (x^7+x^3+1, zero start) over those first 40 bits, and a 1. When `cmd_oe` is 0, `cmd_out` is 1.
- R3: A `cmd_wr` while `cmd_inhibit` is 1 is ignored. The frame on the line and the later outcome are those of the first command.
- R4: An accepted word with bit 21 set, or with `cmd_word[17:16]`=3, sets `dat_inhibit`. It stays set until a `dat_release` pulse. On accept, `xfer_read`, `xfer_multi` and `xfer_cnt_en` take bits 4, 5 and 1 of the word.
- R5: A response type of 0 raises `evt_done` right after the frame, with no wait for a reply.
- R6: Response type 2 or 3 expects 48 bits. The bits are a start 0, a 0, a 6-bit index, 32 status bits, CRC7 over the first 40 bits, and a stop 1. The status bits go to `resp_words[31:0]`, and the upper 96 bits are zeroed.
- R7: Response type 1 expects 136 bits. The bits are two 0s, six 1s, a 120-bit payload, its CRC7, and a stop 1. The payload goes to `resp_words[119:0]` with bits 127:120 zero, so the CRC byte is dropped.
- R8: If no start bit is seen within 64 cycles of the frame ending, `evt_timeout` pulses. `resp_words` keeps its previous value.
- R9: With bit 19 set, a CRC7 mismatch raises `evt_crc`. With bit 19 clear, a bad CRC still ends in `evt_done`.
- R10: With bit 20 set, a 48-bit reply whose index differs from the command index raises `evt_index`. With bit 20 clear, the index is not compared.
- R11: A reply whose stop bit is 0 raises `evt_end`.
- R12: Every command ends with exactly one event cycle, and in that cycle `cmd_inhibit` is already 0. `evt_done` is never high together with an error event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core and card clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wr | input | 1 | Write strobe for the command word |
| cmd_word | input | 32 | Command and mode word |
| cmd_arg | input | 32 | Command argument |
| dat_release | input | 1 | Data engine frees the data lines |
| cmd_in | input | 1 | Command line as received from the card |
| cmd_out | output | 1 | Command line value driven to the card |
| cmd_oe | output | 1 | Output enable for the command line |
| cmd_inhibit | output | 1 | Command in progress |
| dat_inhibit | output | 1 | Data lines reserved |
| xfer_read | output | 1 | Latched direction: 1 means card to host |
| xfer_multi | output | 1 | Latched multi-block flag |
| xfer_cnt_en | output | 1 | Latched block-count enable |
| resp_words | output | 128 | Captured response, word 0 in bits 31:0 |
| evt_done | output | 1 | Command finished without error (pulse) |
| evt_timeout | output | 1 | No response start bit (pulse) |
| evt_crc | output | 1 | Response CRC mismatch (pulse) |
| evt_index | output | 1 | Response index mismatch (pulse) |
| evt_end | output | 1 | Response stop bit was 0 (pulse) |

## Verification
A wrong latched index, argument or response type appears within 48 cycles as a bad bit in the frame on `cmd_out`. It also shows as the wrong expected reply length, which ends in a timeout or a wrong event one reply length later. A wrong bit counter or wait counter in the receiver moves or drops the event and shifts every captured response bit, so the check made in the event cycle catches it. An inhibit flag that is never cleared makes the next command disappear, and the bench sees that as a missing frame.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  localparam int CMD_LEN   = 48;
  localparam int SHORT_LEN = 48;
  localparam int LONG_LEN  = 136;
  localparam int KEEP_W    = 128;
  localparam int PAY_W     = 120;

  typedef enum logic [1:0] {
    RSP_NONE  = 2'd0,
    RSP_LONG  = 2'd1,
    RSP_SHORT = 2'd2,
    RSP_BUSY  = 2'd3
  } rsp_kind_e;

  typedef struct packed {
    logic [5:0] idx;
    rsp_kind_e  kind;
    logic       crc_chk;
    logic       idx_chk;
    logic       uses_dat;
    logic       rd_dir;
    logic       multi;
    logic       cnt_en;
  } cmd_fields_t;

  // CRC7, polynomial x^7+x^3+1, over the low nbits of bits, MSB first
  function automatic logic [6:0] crc7_of(input logic [PAY_W-1:0] bits, input int nbits);
    logic [6:0] c;
    logic       fb;
    c = '0;
    for (int i = PAY_W - 1; i >= 0; i--) begin
      if (i < nbits) begin
        fb = bits[i] ^ c[6];
        c  = {c[5:0], 1'b0};
        if (fb) c = c ^ 7'h09;
      end
    end
    return c;
  endfunction
endpackage

// File: rtl/sdc_cmd_decode.sv
module sdc_cmd_decode
  import sdc_pkg::*;
(
  input  logic [31:0]        cmd_word,
  input  logic [31:0]        cmd_arg,
  output cmd_fields_t        fields,
  output logic [CMD_LEN-1:0] frame
);
  logic unused_bits;
  logic [39:0] head;

  assign unused_bits = ^{cmd_word[31:30], cmd_word[23:22], cmd_word[18],
                         cmd_word[15:6], cmd_word[3:2], cmd_word[0]};

  always_comb begin
    fields.idx      = cmd_word[29:24];
    fields.kind     = rsp_kind_e'(cmd_word[17:16]);
    fields.crc_chk  = cmd_word[19];
    fields.idx_chk  = cmd_word[20];
    fields.uses_dat = cmd_word[21];
    fields.rd_dir   = cmd_word[4];
    fields.multi    = cmd_word[5];
    fields.cnt_en   = cmd_word[1];
  end

  assign head  = {1'b0, 1'b1, cmd_word[29:24], cmd_arg};
  assign frame = {head, crc7_of({{(PAY_W-40){1'b0}}, head}, 40), 1'b1};
endmodule

// File: rtl/sdc_cmd_tx.sv
module sdc_cmd_tx #(
  parameter int FRAME_W = 48
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame,
  output logic               line,
  output logic               oe,
  output logic               fin
);
  localparam int CW = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] sr;
  logic [CW-1:0]      cnt;
  logic               active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr     <= '0;
      cnt    <= '0;
      active <= 1'b0;
      fin    <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (load && !active) begin
        sr     <= frame;
        cnt    <= CW'(FRAME_W);
        active <= 1'b1;
      end else if (active) begin
        sr  <= {sr[FRAME_W-2:0], 1'b1};
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          active <= 1'b0;
          fin    <= 1'b1;
        end
      end
    end
  end

  assign line = active ? sr[FRAME_W-1] : 1'b1;
  assign oe   = active;

  AST_LINE_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> line); // R2
  AST_START_BIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe) |-> !line); // R2
  AST_FIN_AFTER_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> $past(oe) && !oe); // R2
endmodule

// File: rtl/sdc_resp_rx.sv
module sdc_resp_rx #(
  parameter int TIMEOUT_CYC = 64,
  parameter int SHORT_W     = 48,
  parameter int LONG_W      = 136,
  parameter int KEEP_W      = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              long_fmt,
  input  logic              line,
  output logic [KEEP_W-1:0] frame,
  output logic              got,
  output logic              tmo
);
  localparam int WW = $clog2(TIMEOUT_CYC + 1);
  localparam int BW = $clog2(LONG_W + 1);

  typedef enum logic [1:0] {RX_IDLE, RX_WAIT, RX_SHIFT} rx_state_e;

  rx_state_e      st;
  logic [WW-1:0]  wcnt;
  logic [BW-1:0]  bcnt;
  logic           long_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= RX_IDLE;
      wcnt   <= '0;
      bcnt   <= '0;
      long_q <= 1'b0;
      frame  <= '0;
      got    <= 1'b0;
      tmo    <= 1'b0;
    end else begin
      got <= 1'b0;
      tmo <= 1'b0;
      unique case (st)
        RX_IDLE: if (arm) begin
          st     <= RX_WAIT;
          wcnt   <= '0;
          long_q <= long_fmt;
          frame  <= '0;
        end
        RX_WAIT: begin
          if (!line) begin
            st    <= RX_SHIFT;
            frame <= {frame[KEEP_W-2:0], 1'b0};
            bcnt  <= long_q ? BW'(LONG_W - 1) : BW'(SHORT_W - 1);
          end else if (wcnt == WW'(TIMEOUT_CYC - 1)) begin
            st  <= RX_IDLE;
            tmo <= 1'b1;
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
        RX_SHIFT: begin
          frame <= {frame[KEEP_W-2:0], line};
          bcnt  <= bcnt - 1'b1;
          if (bcnt == BW'(1)) begin
            st  <= RX_IDLE;
            got <= 1'b1;
          end
        end
        default: st <= RX_IDLE;
      endcase
    end
  end

  AST_RX_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    !(got && tmo)); // R8
  AST_TMO_FROM_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    tmo |-> $past(st == RX_WAIT) && $past(line)); // R8
endmodule

// File: rtl/sdc_cmd_issue.sv
module sdc_cmd_issue
  import sdc_pkg::*;
#(
  parameter int TIMEOUT_CYC = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd_wr,
  input  logic [31:0]  cmd_word,
  input  logic [31:0]  cmd_arg,
  input  logic         dat_release,
  input  logic         cmd_in,
  output logic         cmd_out,
  output logic         cmd_oe,
  output logic         cmd_inhibit,
  output logic         dat_inhibit,
  output logic         xfer_read,
  output logic         xfer_multi,
  output logic         xfer_cnt_en,
  output logic [127:0] resp_words,
  output logic         evt_done,
  output logic         evt_timeout,
  output logic         evt_crc,
  output logic         evt_index,
  output logic         evt_end
);
  cmd_fields_t        dec_f;
  logic [CMD_LEN-1:0] dec_frame;
  logic               accept;
  logic [5:0]         cur_idx;
  rsp_kind_e          cur_kind;
  logic               cur_crc, cur_ix;
  logic               tx_fin, rx_got, rx_tmo, rx_arm;
  logic [KEEP_W-1:0]  rx_frame;
  logic               cur_long, bad_crc, bad_idx, bad_end, cmd_over;
  logic [6:0]         crc_calc;

  sdc_cmd_decode u_dec (
    .cmd_word (cmd_word),
    .cmd_arg  (cmd_arg),
    .fields   (dec_f),
    .frame    (dec_frame)
  );

  assign accept = cmd_wr && !cmd_inhibit;

  sdc_cmd_tx #(.FRAME_W(CMD_LEN)) u_tx (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept),
    .frame (dec_frame),
    .line  (cmd_out),
    .oe    (cmd_oe),
    .fin   (tx_fin)
  );

  assign rx_arm   = tx_fin && (cur_kind != RSP_NONE);
  assign cur_long = (cur_kind == RSP_LONG);

  sdc_resp_rx #(
    .TIMEOUT_CYC (TIMEOUT_CYC),
    .SHORT_W     (SHORT_LEN),
    .LONG_W      (LONG_LEN),
    .KEEP_W      (KEEP_W)
  ) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm      (rx_arm),
    .long_fmt (cur_long),
    .line     (cmd_in),
    .frame    (rx_frame),
    .got      (rx_got),
    .tmo      (rx_tmo)
  );

  // response checks, evaluated in the cycle the last bit has landed
  always_comb begin
    crc_calc = cur_long ? crc7_of(rx_frame[127:8], PAY_W)
                        : crc7_of({{(PAY_W-40){1'b0}}, rx_frame[47:8]}, 40);
    bad_crc  = cur_crc && (crc_calc != rx_frame[7:1]);
    bad_idx  = cur_ix && !cur_long && (rx_frame[45:40] != cur_idx);
    bad_end  = !rx_frame[0];
  end

  assign cmd_over = (tx_fin && cur_kind == RSP_NONE) || rx_tmo || rx_got;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_idx     <= '0;
      cur_kind    <= RSP_NONE;
      cur_crc     <= 1'b0;
      cur_ix      <= 1'b0;
      xfer_read   <= 1'b0;
      xfer_multi  <= 1'b0;
      xfer_cnt_en <= 1'b0;
      cmd_inhibit <= 1'b0;
      dat_inhibit <= 1'b0;
      resp_words  <= '0;
      evt_done    <= 1'b0;
      evt_timeout <= 1'b0;
      evt_crc     <= 1'b0;
      evt_index   <= 1'b0;
      evt_end     <= 1'b0;
    end else begin
      evt_done    <= 1'b0;
      evt_timeout <= 1'b0;
      evt_crc     <= 1'b0;
      evt_index   <= 1'b0;
      evt_end     <= 1'b0;
      if (accept) begin
        cur_idx     <= dec_f.idx;
        cur_kind    <= dec_f.kind;
        cur_crc     <= dec_f.crc_chk;
        cur_ix      <= dec_f.idx_chk;
        xfer_read   <= dec_f.rd_dir;
        xfer_multi  <= dec_f.multi;
        xfer_cnt_en <= dec_f.cnt_en;
        cmd_inhibit <= 1'b1;
      end else if (cmd_over) begin
        cmd_inhibit <= 1'b0;
      end
      if (accept && (dec_f.uses_dat || dec_f.kind == RSP_BUSY))
        dat_inhibit <= 1'b1;
      else if (dat_release)
        dat_inhibit <= 1'b0;
      if (tx_fin && cur_kind == RSP_NONE) evt_done <= 1'b1;
      if (rx_tmo) evt_timeout <= 1'b1;
      if (rx_got) begin
        evt_crc   <= bad_crc;
        evt_index <= bad_idx;
        evt_end   <= bad_end;
        evt_done  <= !(bad_crc || bad_idx || bad_end);
        resp_words <= cur_long ? {8'h00, rx_frame[127:8]}
                               : {96'h0, rx_frame[39:8]};
      end
    end
  end

  AST_TX_UNDER_INHIBIT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_oe |-> cmd_inhibit); // R2
  AST_BUSY_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_inhibit && cmd_wr) |=> $stable(cur_idx) && $stable(cur_kind)); // R3
  AST_DAT_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (dec_f.uses_dat || dec_f.kind == RSP_BUSY)) |=> dat_inhibit); // R4
  AST_DONE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    evt_done |-> !(evt_timeout || evt_crc || evt_index || evt_end)); // R12
  AST_EVENT_FREES_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_done || evt_timeout || evt_crc || evt_index || evt_end) |-> !cmd_inhibit); // R12
  AST_TMO_KEEPS_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    evt_timeout |-> $stable(resp_words)); // R8
endmodule

// File: tb/sdc_cmd_issue_bench.sv
module sdc_cmd_issue_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cmd_wr = 1'b0;
  logic [31:0]  cmd_word = '0;
  logic [31:0]  cmd_arg = '0;
  logic         dat_release = 1'b0;
  logic         cmd_in = 1'b1;
  logic         cmd_out, cmd_oe, cmd_inhibit, dat_inhibit;
  logic         xfer_read, xfer_multi, xfer_cnt_en;
  logic [127:0] resp_words;
  logic         evt_done, evt_timeout, evt_crc, evt_index, evt_end;

  int tests = 0;
  int fails = 0;
  logic [127:0] exp_resp = '0;

  always #5 clk = ~clk;

  sdc_cmd_issue u_sdc_cmd_issue (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_word(cmd_word),
    .cmd_arg(cmd_arg), .dat_release(dat_release), .cmd_in(cmd_in),
    .cmd_out(cmd_out), .cmd_oe(cmd_oe), .cmd_inhibit(cmd_inhibit),
    .dat_inhibit(dat_inhibit), .xfer_read(xfer_read), .xfer_multi(xfer_multi),
    .xfer_cnt_en(xfer_cnt_en), .resp_words(resp_words), .evt_done(evt_done),
    .evt_timeout(evt_timeout), .evt_crc(evt_crc), .evt_index(evt_index),
    .evt_end(evt_end)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // augmented long division: shift the message then seven zeros through
  function automatic logic [6:0] ref_crc(input logic [119:0] msg, input int n);
    logic [6:0] r = '0;
    logic       top;
    for (int k = n + 6; k >= 0; k--) begin
      top = r[6];
      r   = {r[5:0], (k >= 7) ? msg[k-7] : 1'b0};
      if (top) r = r ^ 7'h09;
    end
    return r;
  endfunction

  // mode: 0 good reply, 1 bad crc, 2 bad index, 3 bad stop bit, 4 silent card
  task automatic issue(input logic [31:0] w, input logic [31:0] a, input int mode,
                       input int dly, input bit poke);
    logic [1:0]   kind = w[17:16];
    logic [39:0]  hd = {2'b01, w[29:24], a};
    logic [47:0]  exp_f = {hd, ref_crc({80'h0, hd}, 40), 1'b1};
    logic [47:0]  got_f = '0;
    logic [135:0] rsp = '0;
    logic [119:0] pay;
    logic [31:0]  stat;
    logic [5:0]   ridx;
    logic [4:0]   ev = '0;
    logic [4:0]   exp_ev;
    bit           dat_exp = w[21] || (kind == 2'd3);
    int           rlen;
    bit           replies = (kind != 2'd0) && (mode != 4);

    @(negedge clk);
    cmd_word = w; cmd_arg = a; cmd_wr = 1'b1;
    @(negedge clk);
    cmd_wr = 1'b0;
    check(cmd_inhibit == 1'b1, "R2", "inhibit after accept", 128'(cmd_inhibit), 128'd1);
    check(dat_inhibit == dat_exp, "R4", "data inhibit", 128'(dat_inhibit), 128'(dat_exp));
    check({xfer_read, xfer_multi, xfer_cnt_en} == {w[4], w[5], w[1]}, "R4", "xfer flags",
          128'({xfer_read, xfer_multi, xfer_cnt_en}), 128'({w[4], w[5], w[1]}));
    for (int i = 47; i >= 0; i--) begin
      got_f[i] = cmd_out;
      if (!cmd_oe) got_f[i] = 1'bx;
      if (poke && i == 37) begin
        cmd_word = ~w; cmd_arg = ~a; cmd_wr = 1'b1;
      end else cmd_wr = 1'b0;
      @(negedge clk);
    end
    cmd_wr = 1'b0;
    check(got_f === exp_f, poke ? "R3" : "R2", "command frame", 128'(got_f), 128'(exp_f));
    check(!cmd_oe && cmd_out, "R2", "line released", 128'({cmd_oe, cmd_out}), 128'b01);

    if (replies) begin
      stat = $urandom;
      pay  = {$urandom, $urandom, $urandom, $urandom};
      ridx = (mode == 2) ? (w[29:24] ^ 6'h01) : w[29:24];
      if (kind == 2'd1) begin
        rlen = 136;
        rsp  = {2'b00, 6'h3f, pay, ref_crc(pay, 120), 1'b1};
        exp_resp = {8'h00, pay};
      end else begin
        rlen = 48;
        rsp[47:0] = {2'b00, ridx, stat, ref_crc({80'h0, 2'b00, ridx, stat}, 40), 1'b1};
        exp_resp = {96'h0, stat};
      end
      if (mode == 1) rsp[1] = ~rsp[1];
      if (mode == 3) rsp[0] = 1'b0;
      repeat (dly) @(negedge clk);
      for (int i = rlen - 1; i >= 0; i--) begin
        cmd_in = rsp[i];
        @(negedge clk);
      end
      cmd_in = 1'b1;
    end

    for (int t = 0; t < 300; t++) begin
      ev = {evt_end, evt_index, evt_crc, evt_timeout, evt_done};
      if (ev != 0) break;
      @(negedge clk);
    end
    if (kind == 2'd0) exp_ev = 5'b00001;
    else if (mode == 4) exp_ev = 5'b00010;
    else begin
      exp_ev[4] = (mode == 3);
      exp_ev[3] = (mode == 2) && w[20] && (kind != 2'd1);
      exp_ev[2] = (mode == 1) && w[19];
      exp_ev[1] = 1'b0;
      exp_ev[0] = (exp_ev[4:2] == 3'b000);
    end
    check(ev == exp_ev,
          (mode == 4) ? "R8" : (mode == 1) ? "R9" : (mode == 2) ? "R10" :
          (mode == 3) ? "R11" : (kind == 2'd0) ? "R5" : "R12",
          "event set", 128'(ev), 128'(exp_ev));
    check(cmd_inhibit == 1'b0, "R12", "inhibit cleared at event", 128'(cmd_inhibit), 128'd0);
    if (kind != 2'd0)
      check(resp_words == exp_resp, (kind == 2'd1) ? "R7" : (mode == 4) ? "R8" : "R6",
            "response words", resp_words, exp_resp);
    @(negedge clk);
    check({evt_end, evt_index, evt_crc, evt_timeout, evt_done} == 5'b0, "R12",
          "single event cycle", 128'({evt_end, evt_index, evt_crc, evt_timeout, evt_done}), 128'd0);
    if (dat_exp) begin
      check(dat_inhibit == 1'b1, "R4", "data inhibit held", 128'(dat_inhibit), 128'd1);
      dat_release = 1'b1;
      @(negedge clk);
      dat_release = 1'b0;
      check(dat_inhibit == 1'b0, "R4", "data inhibit released", 128'(dat_inhibit), 128'd0);
    end
  endtask

  function automatic logic [31:0] mk(input logic [5:0] idx, input logic [1:0] kind,
                                     input bit crc, input bit ix, input bit dat);
    return {2'b00, idx, 2'b00, dat, ix, crc, 1'b0, kind, 16'h0};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5d1c));
    repeat (3) @(negedge clk);
    check(!cmd_inhibit && !dat_inhibit && !cmd_oe && cmd_out && resp_words == '0 &&
          !evt_done && !evt_timeout && !evt_crc && !evt_index && !evt_end, "R1",
          "reset state", {cmd_inhibit, dat_inhibit, cmd_oe, cmd_out}, 128'b0001);
    rst_n = 1'b1;
    @(negedge clk);
    // directed corner cases
    issue(mk(6'd0, 2'd0, 0, 0, 0), 32'h0000_0000, 0, 2, 0);           // R5
    issue(mk(6'd13, 2'd2, 1, 1, 0), 32'h1234_5678, 0, 1, 1);          // R3 R6
    issue(mk(6'd2, 2'd1, 1, 0, 0), 32'hffff_ffff, 0, 3, 0);           // R7
    issue(mk(6'd7, 2'd3, 1, 1, 0), 32'hdead_beef, 0, 64, 0);          // R4 window edge
    issue(mk(6'd17, 2'd2, 1, 1, 1) | 32'h32, 32'h0000_0200, 0, 5, 0); // R4 flags
    issue(mk(6'd8, 2'd2, 1, 1, 0), 32'h0000_01aa, 4, 0, 0);           // R8
    issue(mk(6'd9, 2'd2, 1, 0, 0), 32'h5555_aaaa, 1, 2, 0);           // R9
    issue(mk(6'd9, 2'd2, 0, 0, 0), 32'h5555_aaaa, 1, 2, 0);           // R9 disabled
    issue(mk(6'd55, 2'd2, 1, 1, 0), 32'h0, 2, 2, 0);                  // R10
    issue(mk(6'd55, 2'd2, 1, 0, 0), 32'h0, 2, 2, 0);                  // R10 disabled
    issue(mk(6'd6, 2'd2, 1, 1, 0), 32'h2, 3, 2, 0);                   // R11
    issue(mk(6'd9, 2'd1, 1, 0, 0), 32'h0, 1, 4, 0);                   // R7 R9 long
    // constrained random
    for (int n = 0; n < 30; n++) begin
      logic [31:0] w = $urandom;
      int m = ($urandom % 4 == 0) ? int'(1 + $urandom % 3) : 0;
      issue(w, $urandom, m, int'(1 + $urandom % 20), ($urandom % 5) == 0);
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule